// File: doc/BRIEF.md
# Interrupt Acknowledge Engine

This block is an eight-input priority interrupt controller. Its request register captures incoming requests, either on a rising edge or as a live level. Its in-service register records which requests the processor is currently handling. Its mask register hides chosen requests. Priority is fixed: input 0 is the most urgent and input 7 the least. The interrupt line to the processor is high when some unmasked pending request outranks every request already in service.

The processor answers with two low pulses on an active-low acknowledge strobe, which the block samples on its own clock. On the falling edge of the first pulse, the block picks the winning request, moves it from pending to in-service, and latches its number. If no request qualifies at that moment, the block records number 7 as a spurious choice and changes no in-service state. On the trailing edge of the first pulse, the latched number is published as a 3-bit cascade identifier. A downstream controller uses it to decide whether it owns the second pulse. During the second pulse the block presents the 8-bit vector. The vector is a 5-bit programmable base in bits 7:3 followed by the 3-bit request number in bits 2:0.

The vector output has no back-pressure. The acknowledge strobe alone paces the transfer. `vec_valid` has no ready partner, and the consumer must take `vec_data` while the second pulse is low. In-service bits are cleared either automatically when the second pulse ends, or by a non-specific end-of-interrupt command.

Top module: `intc_ack_engine`

## Requirements
- R1: After reset, `int_out`, `vec_valid` and `cas_valid` are low, and no request is pending, in service or masked.
- R2: In edge mode (`lvl_mode`=0), a request bit becomes pending only after a low-to-high change on its input. An input that is already high when reset ends raises nothing.
- R3: In level mode (`lvl_mode`=1), each pending bit copies its input one clock later, so a request that is withdrawn stops being pending.
- R4: `int_out` is high exactly when the lowest-numbered unmasked pending request has a lower number than every in-service request.
- R5: A `mask_wr` pulse loads `mask_data` into the mask (1 = masked). A masked request stays pending without raising `int_out`, and it raises `int_out` once unmasked.
- R6: On the sampled falling edge of the first acknowledge pulse, the winning request is set in service and removed from pending.
- R7: From the trailing edge of the first pulse until the trailing edge of the second pulse, `cas_valid` is high and `cas_id` holds the chosen request number, unchanged.
- R8: `vec_valid` is high from the clock after the second pulse's falling edge is sampled until its rising edge is sampled. While it is high, `vec_data` = {`vec_base`, chosen number}.
- R9: If no request qualifies when the first pulse starts, the chosen number is 7 and no in-service bit is set.
- R10: With `auto_eoi`=1, the chosen in-service bit clears when the trailing edge of the second pulse is sampled.
- R11: An `eoi_cmd` pulse clears the lowest-numbered set in-service bit.
- R12: An in-service request blocks requests of equal or larger number, and a request with a smaller number still raises `int_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 8 | Request inputs, bit 0 most urgent |
| lvl_mode | input | 1 | 1 = level capture, 0 = rising-edge capture |
| ack_n | input | 1 | Active-low acknowledge strobe, two pulses per interrupt |
| eoi_cmd | input | 1 | One-cycle non-specific end-of-interrupt command |
| mask_wr | input | 1 | Mask register load strobe |
| mask_data | input | 8 | New mask value, 1 = masked |
| auto_eoi | input | 1 | Clear in-service automatically after the second pulse |
| vec_base | input | 5 | Upper vector bits |
| int_out | output | 1 | Interrupt line to the processor |
| vec_valid | output | 1 | Vector qualifier during the second pulse |
| vec_data | output | 8 | Interrupt vector |
| cas_valid | output | 1 | Cascade identifier is being broadcast |
| cas_id | output | 3 | Chosen request number for the cascade bus |

## Verification
The assertions watch the following on every cycle:
- how the pending register follows level inputs, and that in edge mode it is set only by rising edges;
- that `int_out` is never raised by masked-only requests;
- that the winner's in-service bit is set and a spurious pick leaves in-service untouched;
- that automatic and commanded end-of-interrupt each clear exactly one bit;
- that the vector only appears while the cascade identifier is held stable.

The bench scenarios are needed for the effects that span several interrupts. These are the nesting order across overlapping interrupts, a masked request surviving until it is unmasked, the exact vector values for several bases and numbers, and the spurious vector 7 after a withdrawn level request. A behavioural model is also compared against the outputs on every clock.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Which pulse of the two-pulse acknowledge the engine expects next
  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } ack_phase_e;
endpackage

// File: rtl/intc_prio_pick.sv
// Finds the lowest-numbered set bit (highest priority) of a request vector.
module intc_prio_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/intc_req_reg.sv
// Pending-request register with per-input edge or level capture.
module intc_req_reg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lvl_mode,
  input  logic [N-1:0] irq_req,
  input  logic [N-1:0] clr,
  output logic [N-1:0] irr
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        // start high so an input already asserted needs a fresh rise
        prev_q[i] <= 1'b1;
        irr[i]    <= 1'b0;
      end else begin
        prev_q[i] <= irq_req[i];
        if (lvl_mode)
          irr[i] <= irq_req[i];
        else if (irq_req[i] && !prev_q[i])
          irr[i] <= 1'b1;
        else if (clr[i])
          irr[i] <= 1'b0;
      end
    end
  end

  p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_mode |=> (irr == $past(irq_req)));

  p_edge_only_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_mode |=> ((irr & ~$past(irr) & ~($past(irq_req) & ~$past(prev_q))) == '0));
endmodule

// File: rtl/intc_isr_reg.sv
// In-service register: set by the first acknowledge, cleared by EOI or auto-EOI.
module intc_isr_reg #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          eoi_cmd,
  input  logic          aeoi_en,
  input  logic [IW-1:0] aeoi_idx,
  output logic [N-1:0]  isr
);
  logic          top_any;
  logic [IW-1:0] top_idx;
  logic [N-1:0]  isr_next;

  intc_prio_pick #(.N(N), .IW(IW)) u_eoi_pick (
    .req (isr),
    .any (top_any),
    .idx (top_idx)
  );

  always_comb begin
    isr_next = isr;
    if (eoi_cmd && top_any) isr_next[top_idx]  = 1'b0;
    if (aeoi_en)            isr_next[aeoi_idx] = 1'b0;
    if (set_en)             isr_next[set_idx]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr <= '0;
    else        isr <= isr_next;
  end

  p_eoi_one_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_cmd && (isr != '0) && !set_en && !aeoi_en)
      |=> ($countones(isr) == $countones($past(isr)) - 1));

  p_eoi_lowest_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_cmd && top_any && !set_en) |=> !isr[$past(top_idx)]);
endmodule

// File: rtl/intc_ack_engine.sv
// Eight-input fully nested interrupt controller with two-pulse acknowledge.
module intc_ack_engine
  import intc_pkg::*;
#(
  parameter int N_IRQ  = 8,
  parameter int VEC_W  = 8,
  parameter int ID_W   = $clog2(N_IRQ),
  parameter int BASE_W = VEC_W - ID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic              lvl_mode,
  input  logic              ack_n,
  input  logic              eoi_cmd,
  input  logic              mask_wr,
  input  logic [N_IRQ-1:0]  mask_data,
  input  logic              auto_eoi,
  input  logic [BASE_W-1:0] vec_base,
  output logic              int_out,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_data,
  output logic              cas_valid,
  output logic [ID_W-1:0]   cas_id
);
  localparam logic [ID_W-1:0] SPUR_ID = ID_W'(N_IRQ - 1);

  logic [N_IRQ-1:0] irr, isr, imr, elig, irr_clr;
  logic             e_any, s_any, win_valid;
  logic [ID_W-1:0]  e_idx, s_idx;
  logic             ack_prev, ack_fall, ack_rise;
  logic             first_go, first_end, second_end;
  ack_phase_e       phase;
  logic [ID_W-1:0]  sel_id;
  logic             sel_real;

  // ---- mask register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       imr <= '0;
    else if (mask_wr) imr <= mask_data;
  end

  // ---- priority resolution
  assign elig = irr & ~imr;

  intc_prio_pick #(.N(N_IRQ), .IW(ID_W)) u_req_pick (
    .req (elig), .any (e_any), .idx (e_idx)
  );
  intc_prio_pick #(.N(N_IRQ), .IW(ID_W)) u_srv_pick (
    .req (isr), .any (s_any), .idx (s_idx)
  );

  assign win_valid = e_any && (!s_any || (e_idx < s_idx));
  assign int_out   = win_valid;

  p_int_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~imr) != '0));

  // ---- acknowledge strobe edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_prev <= 1'b1;
    else        ack_prev <= ack_n;
  end

  assign ack_fall   = ack_prev & ~ack_n;
  assign ack_rise   = ~ack_prev & ack_n;
  assign first_go   = ack_fall && (phase == PH_FIRST);
  assign first_end  = ack_rise && (phase == PH_FIRST);
  assign second_end = ack_rise && (phase == PH_SECOND);

  // ---- sequencer: choice, cascade broadcast, phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_FIRST;
      sel_id    <= '0;
      sel_real  <= 1'b0;
      cas_valid <= 1'b0;
      cas_id    <= '0;
    end else begin
      if (first_go) begin
        sel_id   <= win_valid ? e_idx : SPUR_ID;
        sel_real <= win_valid;
      end
      if (first_end) begin
        phase     <= PH_SECOND;
        cas_id    <= sel_id;
        cas_valid <= 1'b1;
      end else if (second_end) begin
        phase     <= PH_FIRST;
        cas_valid <= 1'b0;
      end
    end
  end

  assign vec_valid = (phase == PH_SECOND) && !ack_prev;
  assign vec_data  = {vec_base, sel_id};

  // ---- pending and in-service registers
  always_comb begin
    irr_clr = '0;
    if (first_go && win_valid) irr_clr[e_idx] = 1'b1;
  end

  intc_req_reg #(.N(N_IRQ)) u_irr (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_mode (lvl_mode),
    .irq_req  (irq_req),
    .clr      (irr_clr),
    .irr      (irr)
  );

  intc_isr_reg #(.N(N_IRQ), .IW(ID_W)) u_isr (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (first_go && win_valid),
    .set_idx  (e_idx),
    .eoi_cmd  (eoi_cmd),
    .aeoi_en  (second_end && auto_eoi && sel_real),
    .aeoi_idx (sel_id),
    .isr      (isr)
  );

  // ---- checks on the acknowledge handshake
  p_isr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (first_go && win_valid) |=> isr[$past(e_idx)]);

  p_spurious_no_isr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (first_go && !win_valid && !eoi_cmd) |=> ((isr == $past(isr)) && (sel_id == SPUR_ID)));

  p_cas_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_valid && $past(cas_valid)) |-> $stable(cas_id));

  p_vec_in_second_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> cas_valid);

  p_auto_eoi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (second_end && auto_eoi && sel_real && !first_go) |=> !isr[$past(sel_id)]);
endmodule

// File: tb/intc_ack_engine_test.sv
module intc_ack_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_req = 8'h00;
  logic       lvl_mode = 1'b0;
  logic       ack_n = 1'b1;
  logic       eoi_cmd = 1'b0;
  logic       mask_wr = 1'b0;
  logic [7:0] mask_data = 8'h00;
  logic       auto_eoi = 1'b0;
  logic [4:0] vec_base = 5'h0A;
  logic       int_out, vec_valid, cas_valid;
  logic [7:0] vec_data;
  logic [2:0] cas_id;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  intc_ack_engine uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .lvl_mode(lvl_mode),
    .ack_n(ack_n), .eoi_cmd(eoi_cmd), .mask_wr(mask_wr), .mask_data(mask_data),
    .auto_eoi(auto_eoi), .vec_base(vec_base), .int_out(int_out),
    .vec_valid(vec_valid), .vec_data(vec_data), .cas_valid(cas_valid),
    .cas_id(cas_id)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_irr, m_isr, m_imr, m_prev;
  bit         m_ackp, m_phase, m_real, m_casv;
  int         m_sel, m_cas;

  function automatic int m_winner();
    for (int i = 0; i < 8; i++) begin
      if (m_isr[i]) return -1;
      if (m_irr[i] && !m_imr[i]) return i;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_irr = 8'h00; m_isr = 8'h00; m_imr = 8'h00; m_prev = 8'hFF;
      m_ackp = 1'b1; m_phase = 1'b0; m_real = 1'b0; m_casv = 1'b0;
      m_sel = 0; m_cas = 0;
    end else begin
      int w;
      bit fall, rise;
      w = m_winner();
      fall = m_ackp && !ack_n;
      rise = !m_ackp && ack_n;
      if (eoi_cmd) begin
        for (int i = 0; i < 8; i++) begin
          if (m_isr[i]) begin m_isr[i] = 1'b0; break; end
        end
      end
      if (fall && !m_phase) begin
        m_real = (w >= 0);
        m_sel  = m_real ? w : 7;
        if (m_real) begin m_isr[w] = 1'b1; m_irr[w] = 1'b0; end
      end
      if (rise && !m_phase) begin
        m_phase = 1'b1; m_cas = m_sel; m_casv = 1'b1;
      end else if (rise && m_phase) begin
        if (auto_eoi && m_real) m_isr[m_sel] = 1'b0;
        m_phase = 1'b0; m_casv = 1'b0;
      end
      for (int i = 0; i < 8; i++) begin
        if (lvl_mode) m_irr[i] = irq_req[i];
        else if (irq_req[i] && !m_prev[i]) m_irr[i] = 1'b1;
      end
      if (mask_wr) m_imr = mask_data;
      m_prev = irq_req;
      m_ackp = ack_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ei, ev;
      ei = (m_winner() >= 0);
      ev = m_phase && !m_ackp;
      chk(int_out == ei, "R4 model int_out", int_out, ei);
      chk(vec_valid == ev, "R8 model vec_valid", vec_valid, ev);
      if (ev) chk(vec_data == {vec_base, 3'(m_sel)}, "R8 model vec_data", vec_data, {vec_base, 3'(m_sel)});
      chk(cas_valid == m_casv, "R7 model cas_valid", cas_valid, m_casv);
      if (m_casv) chk(cas_id == 3'(m_cas), "R7 model cas_id", cas_id, m_cas);
    end
  end

  // ---------------- stimulus helpers (all start and end at a negedge) ----------------
  task automatic pulse_irq(input int i);
    irq_req[i] = 1'b1;
    @(negedge clk);
    irq_req[i] = 1'b0;
  endtask

  task automatic send_eoi();
    eoi_cmd = 1'b1;
    @(negedge clk);
    eoi_cmd = 1'b0;
  endtask

  task automatic load_mask(input logic [7:0] m);
    mask_wr = 1'b1; mask_data = m;
    @(negedge clk);
    mask_wr = 1'b0;
  endtask

  task automatic ack_seq(output logic [7:0] v, output logic [2:0] c,
                         output logic vs, output logic cs);
    ack_n = 1'b0; repeat (2) @(negedge clk);
    ack_n = 1'b1; repeat (2) @(negedge clk);
    cs = cas_valid; c = cas_id;
    ack_n = 1'b0; repeat (2) @(negedge clk);
    vs = vec_valid; v = vec_data;
    ack_n = 1'b1; repeat (2) @(negedge clk);
  endtask

  task automatic ack_expect(input logic [7:0] ev, input logic [2:0] ec, input string tag);
    logic [7:0] v; logic [2:0] c; logic vs, cs;
    ack_seq(v, c, vs, cs);
    chk(cs && c == ec, {tag, " cascade id"}, {cs, c}, {1'b1, ec});
    chk(vs && v == ev, {tag, " vector"}, {vs, v}, {1'b1, ev});
    chk(!vec_valid && !cas_valid, {tag, " handshake idle"}, {vec_valid, cas_valid}, 0);
  endtask

  // ---------------- scenarios ----------------
  initial begin
    irq_req = 8'h01;                     // held high through reset
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!int_out && !vec_valid && !cas_valid, "R1 reset outputs",
        {int_out, vec_valid, cas_valid}, 0);
    repeat (2) @(negedge clk);
    chk(!int_out, "R2 held-high input ignored", int_out, 0);
    irq_req = 8'h00;
    @(negedge clk);
    pulse_irq(0);
    chk(int_out, "R2 rising edge requests", int_out, 1);

    ack_expect(8'h50, 3'd0, "R8 irq0");
    chk(!int_out, "R6 winner now in service", int_out, 0);
    send_eoi();
    chk(!int_out, "R6 pending bit removed", int_out, 0);

    pulse_irq(3);
    ack_expect(8'h53, 3'd3, "R7 irq3");
    pulse_irq(0);
    chk(int_out, "R12 higher priority nests", int_out, 1);
    ack_expect(8'h50, 3'd0, "R8 nested irq0");
    send_eoi();
    chk(!int_out, "R11 eoi cleared irq0 only", int_out, 0);
    pulse_irq(3);
    chk(!int_out, "R12 equal priority blocked", int_out, 0);
    send_eoi();
    chk(int_out, "R11 eoi cleared irq3", int_out, 1);
    ack_expect(8'h53, 3'd3, "R8 irq3 again");
    send_eoi();
    chk(!int_out, "R11 all clear", int_out, 0);

    load_mask(8'h04);
    pulse_irq(2);
    chk(!int_out, "R5 masked request silent", int_out, 0);
    load_mask(8'h00);
    chk(int_out, "R5 unmasked request raises", int_out, 1);
    ack_expect(8'h52, 3'd2, "R5 irq2");
    send_eoi();

    vec_base = 5'h13;
    auto_eoi = 1'b1;
    pulse_irq(1);
    ack_expect(8'h99, 3'd1, "R10 irq1");
    pulse_irq(4);
    chk(int_out, "R10 irq1 auto cleared", int_out, 1);
    ack_expect(8'h9C, 3'd4, "R10 irq4");
    pulse_irq(4);
    chk(int_out, "R10 irq4 auto cleared", int_out, 1);
    ack_expect(8'h9C, 3'd4, "R10 irq4 again");
    auto_eoi = 1'b0;
    vec_base = 5'h0A;

    lvl_mode = 1'b1;
    irq_req[5] = 1'b1;
    repeat (2) @(negedge clk);
    chk(int_out, "R3 level request", int_out, 1);
    irq_req[5] = 1'b0;
    @(negedge clk);
    chk(!int_out, "R3 withdrawn level", int_out, 0);
    irq_req[5] = 1'b1;
    @(negedge clk);
    irq_req[5] = 1'b0;
    @(negedge clk);
    ack_expect(8'h57, 3'd7, "R9 spurious");
    irq_req[6] = 1'b1;
    repeat (2) @(negedge clk);
    chk(int_out, "R9 spurious set no in-service", int_out, 1);
    ack_expect(8'h56, 3'd6, "R8 level irq6");
    chk(!int_out, "R12 level irq6 blocked by itself", int_out, 0);
    send_eoi();
    chk(int_out, "R11 level irq6 reasserts", int_out, 1);
    irq_req[6] = 1'b0;
    @(negedge clk);
    chk(!int_out, "R3 level drop", int_out, 0);
    lvl_mode = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule